// File: doc/BRIEF.md
# Pad Coincidence Trigger Road Finder

This block looks at the pad-hit maps of eight detector layers once per bunch crossing. The layers form two groups of four, an inner and an outer quadruplet. Pads on odd layers sit half a pad width away from pads on even layers. The block therefore scans a grid of half-pad "towers" rather than raw pad indices. Inside each quadruplet a tower is a candidate when at least three of its four layers fire. A trigger road exists where both quadruplets hold a candidate in the same tower.

At most three roads leave per crossing, and the roads with the lowest band numbers win. Each road becomes a 25-bit word made of the crossing number, the band number of its tower and the sector's azimuthal number. The words are shifted out on two serial lanes, most significant bit first and interleaved across the lanes. A frame line is high while word bits are on the lanes. The path from the crossing strobe to the first framed bit has a fixed length. A new crossing may only be strobed once the previous crossing's output has finished, which takes up to 39 cycles.

Top module: `pad_road_finder`

## Requirements
- R1: While reset is held and after it is released with no crossing strobed, `frame_o`, `lane0_o` and `lane1_o` are all 0.
- R2: In each quadruplet (layers 0..3 and layers 4..7) a tower is a candidate only when at least three of its four layers cover it with a hit. Two layers out of four give no candidate.
- R3: With NPAD pads per layer there are 2*NPAD towers. A hit on pad p of an even layer covers towers 2p and 2p+1. A hit on pad p of an odd layer covers towers 2p+1 and 2p+2, when that tower exists. Tower 0 can therefore never be a candidate.
- R4: A road is formed only in a tower that is a candidate in both quadruplets. Candidates in one quadruplet alone, or in different towers of the two quadruplets, give no road.
- R5: When more than three roads qualify in a crossing, only the three with the lowest band numbers are sent. Words go out in ascending band order.
- R6: The band number of tower t is BAND_BASE + t*BAND_STEP, taken modulo 256. The defaults are 16 and 3.
- R7: A road word is {crossing[11:0], band[7:0], phi[4:0]}. The crossing number occupies bits 24..13, the band bits 12..5 and the phi bits 4..0. The crossing number is `bx_num` sampled with the strobe, and phi is `sector_phi`.
- R8: A word takes 13 cycles. In cycle k (k = 0..12) of the word, `lane0_o` carries bit 24-2k and `lane1_o` carries bit 23-2k. In cycle 12, `lane1_o` carries 0.
- R9: For a crossing with n roads, `frame_o` is high for exactly 13*n consecutive cycles. The words follow one another with no gap, and the lanes are 0 while `frame_o` is low.
- R10: When `bx_stb` is sampled high at clock edge E, the first framed bit is visible after edge E+2, whatever the road count. `frame_o` is low after edges E and E+1.
- R11: A strobed crossing with no road keeps `frame_o` low.
- R12: Pad hits presented while `bx_stb` is low produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_stb | input | 1 | Marks the cycle that carries a crossing's pad hits |
| bx_num | input | 12 | Crossing number, sampled with the strobe |
| pad_hits | input | 8*NPAD | Pad-hit bits. Layer L occupies bits [L*NPAD +: NPAD], bit p is pad p |
| sector_phi | input | 5 | Azimuthal number of the sector |
| frame_o | output | 1 | High while road word bits are on the lanes |
| lane0_o | output | 1 | Serial lane carrying the even-offset bits |
| lane1_o | output | 1 | Serial lane carrying the odd-offset bits |

## Verification
Single-pad patterns place three or four layers on one pad. They show whether the majority vote and the half-pad tower mapping hold, including the last tower of the grid. Two-layer patterns, one-sided patterns and patterns where the two quadruplets disagree must all stay silent. These separate the in-quadruplet vote from the cross-quadruplet agreement. Patterns with exactly three roads and with five roads check the cap, the lowest-band selection, the word order and the frame length. Idle hits without a strobe and an empty strobed crossing confirm that nothing leaks onto the frame.

// File: rtl/pad_road_pkg.sv
package pad_road_pkg;

  localparam int NLAYER  = 8;
  localparam int QLAYERS = 4;
  localparam int BCID_W  = 12;
  localparam int BAND_W  = 8;
  localparam int PHI_W   = 5;
  localparam int WORD_W  = BCID_W + BAND_W + PHI_W;

  typedef struct packed {
    logic [BCID_W-1:0] bcid;
    logic [BAND_W-1:0] band;
    logic [PHI_W-1:0]  phi;
  } road_word_t;

  // Majority vote: at least three of four layers see the tower
  function automatic logic vote3of4(input logic [QLAYERS-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < QLAYERS; i++) n += int'(v[i]);
    return (n >= 3);
  endfunction

  // Computed band lookup: linear in tower index
  function automatic logic [BAND_W-1:0] band_of(input logic [BAND_W-1:0] base,
                                                input logic [BAND_W-1:0] step,
                                                input int              tower);
    return base + BAND_W'(tower) * step;
  endfunction

endpackage

// File: rtl/prf_coinc.sv
module prf_coinc
  import pad_road_pkg::*;
#(
  parameter int NPAD = 16,
  localparam int NTOW = 2 * NPAD
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stb,
  input  logic [NLAYER*NPAD-1:0]   hits,
  input  logic [BCID_W-1:0]        bcid_in,
  output logic                     vld_q,
  output logic [NTOW-1:0]          road_q,
  output logic [BCID_W-1:0]        bcid_q
);

  logic [NTOW-1:0] cand_in;   // inner quadruplet candidates
  logic [NTOW-1:0] cand_out;  // outer quadruplet candidates
  logic [NTOW-1:0] road_c;

  for (genvar t = 0; t < NTOW; t++) begin : g_tow
    logic [NLAYER-1:0] cov;
    for (genvar l = 0; l < NLAYER; l++) begin : g_lay
      if (l % 2 == 0) begin : g_even
        assign cov[l] = hits[l*NPAD + t/2];
      end else if (t == 0) begin : g_edge
        assign cov[l] = 1'b0;
      end else begin : g_odd
        assign cov[l] = hits[l*NPAD + (t-1)/2];
      end
    end
    assign cand_in[t]  = vote3of4(cov[QLAYERS-1:0]);
    assign cand_out[t] = vote3of4(cov[NLAYER-1:QLAYERS]);
  end

  assign road_c = cand_in & cand_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      road_q <= '0;
      bcid_q <= '0;
    end else begin
      vld_q <= stb;
      if (stb) begin
        road_q <= road_c;
        bcid_q <= bcid_in;
      end
    end
  end

endmodule

// File: rtl/prf_select.sv
module prf_select
  import pad_road_pkg::*;
#(
  parameter int                NTOW      = 32,
  parameter int                MAXR      = 3,
  parameter logic [BAND_W-1:0] BAND_BASE = 8'h10,
  parameter logic [BAND_W-1:0] BAND_STEP = 8'd3,
  localparam int CW = $clog2(MAXR + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_vld,
  input  logic [NTOW-1:0]             roads,
  input  logic [BCID_W-1:0]           bcid,
  input  logic [PHI_W-1:0]            phi,
  output logic                        out_vld,
  output logic [CW-1:0]               out_n,
  output road_word_t [MAXR-1:0]       words_q
);

  logic [NTOW-1:0]        rem [MAXR+1];
  logic [MAXR-1:0]        found;
  road_word_t [MAXR-1:0]  words_c;
  logic [CW-1:0]          n_c;

  assign rem[0] = roads;

  // Cascade of lowest-bit pickers; lowest tower means lowest band
  for (genvar s = 0; s < MAXR; s++) begin : g_slot
    logic [NTOW-1:0] lsb;
    int              idx;
    assign lsb        = rem[s] & (-rem[s]);
    assign found[s]   = |rem[s];
    assign rem[s+1]   = rem[s] & ~lsb;
    always_comb begin
      idx = 0;
      for (int t = 0; t < NTOW; t++) if (lsb[t]) idx = t;
    end
    assign words_c[s] = found[s] ? {bcid, band_of(BAND_BASE, BAND_STEP, idx), phi}
                                 : '0;
  end

  always_comb begin
    n_c = '0;
    for (int s = 0; s < MAXR; s++) n_c = n_c + CW'(found[s]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_n   <= '0;
      words_q <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_n   <= n_c;
        words_q <= words_c;
      end
    end
  end

  // Kept words leave in strictly ascending band order
  for (genvar s = 1; s < MAXR; s++) begin : g_ord
    p_band_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && (int'(out_n) > s)) |-> (words_q[s].band > words_q[s-1].band));
  end

endmodule

// File: rtl/prf_serial.sv
module prf_serial
  import pad_road_pkg::*;
#(
  parameter int MAXR = 3,
  localparam int CW    = $clog2(MAXR + 1),
  localparam int HALF  = (WORD_W + 1) / 2,
  localparam int PADW  = 2 * HALF,
  localparam int SHW   = MAXR * PADW,
  localparam int CNT_W = $clog2(MAXR * HALF + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [CW-1:0]         n,
  input  road_word_t [MAXR-1:0] words,
  output logic                  frame,
  output logic                  lane0,
  output logic                  lane1
);

  logic [SHW-1:0]   sh;
  logic [SHW-1:0]   sh_load;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    sh_load = '0;
    for (int s = 0; s < MAXR; s++)
      sh_load[SHW-1-s*PADW -: PADW] = {words[s], {(PADW-WORD_W){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (load) begin
      sh  <= sh_load;
      cnt <= CNT_W'(int'(n) * HALF);
    end else if (cnt != '0) begin
      sh  <= sh << 2;
      cnt <= cnt - 1'b1;
    end
  end

  assign frame = (cnt != '0);
  assign lane0 = frame & sh[SHW-1];
  assign lane1 = frame & sh[SHW-2];

  // Frame only ever opens right after a load
  p_frame_after_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame) |-> $past(load));

  // An empty crossing keeps the frame closed
  p_empty_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (load && n == '0) |=> !frame);

  // Lanes are quiet outside the frame
  p_quiet_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame |-> (!lane0 && !lane1));

endmodule

// File: rtl/pad_road_finder.sv
module pad_road_finder
  import pad_road_pkg::*;
#(
  parameter int                NPAD      = 16,
  parameter int                MAXR      = 3,
  parameter logic [BAND_W-1:0] BAND_BASE = 8'h10,
  parameter logic [BAND_W-1:0] BAND_STEP = 8'd3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bx_stb,
  input  logic [BCID_W-1:0]      bx_num,
  input  logic [NLAYER*NPAD-1:0] pad_hits,
  input  logic [PHI_W-1:0]       sector_phi,
  output logic                   frame_o,
  output logic                   lane0_o,
  output logic                   lane1_o
);

  localparam int NTOW = 2 * NPAD;
  localparam int CW   = $clog2(MAXR + 1);

  logic                  c_vld;
  logic [NTOW-1:0]       c_roads;
  logic [BCID_W-1:0]     c_bcid;
  logic                  s_vld;
  logic [CW-1:0]         s_n;
  road_word_t [MAXR-1:0] s_words;

  prf_coinc #(.NPAD(NPAD)) u_coinc (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (bx_stb),
    .hits    (pad_hits),
    .bcid_in (bx_num),
    .vld_q   (c_vld),
    .road_q  (c_roads),
    .bcid_q  (c_bcid)
  );

  prf_select #(
    .NTOW(NTOW), .MAXR(MAXR), .BAND_BASE(BAND_BASE), .BAND_STEP(BAND_STEP)
  ) u_select (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (c_vld),
    .roads   (c_roads),
    .bcid    (c_bcid),
    .phi     (sector_phi),
    .out_vld (s_vld),
    .out_n   (s_n),
    .words_q (s_words)
  );

  prf_serial #(.MAXR(MAXR)) u_serial (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (s_vld),
    .n     (s_n),
    .words (s_words),
    .frame (frame_o),
    .lane0 (lane0_o),
    .lane1 (lane1_o)
  );

  // Cap: a crowded crossing yields exactly MAXR words
  p_road_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_vld && $countones(c_roads) >= MAXR) |=> (int'(s_n) == MAXR));

  // No coincidence in any tower means nothing to send
  p_no_road_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (c_vld && c_roads == '0) |=> (s_n == '0));

  // Without a strobe the selection stage stays idle
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !c_vld |=> !s_vld);

endmodule

// File: tb/sim_pad_road_finder.sv
module sim_pad_road_finder;

  localparam int NPAD = 16;
  localparam int NTOW = 2 * NPAD;
  localparam int HW   = 8 * NPAD;
  localparam int NCAP = 45;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bx_stb;
  logic [11:0]   bx_num;
  logic [HW-1:0] pad_hits;
  logic [4:0]    sector_phi;
  logic          frame_o, lane0_o, lane1_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int          exp_n;
  logic [24:0] exp_w [3];

  always #4 clk = ~clk;

  pad_road_finder u0 (
    .clk(clk), .rst_n(rst_n), .bx_stb(bx_stb), .bx_num(bx_num),
    .pad_hits(pad_hits), .sector_phi(sector_phi),
    .frame_o(frame_o), .lane0_o(lane0_o), .lane1_o(lane1_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Set one pad in every layer named by the mask
  function automatic logic [HW-1:0] mk(input logic [7:0] lmask, input int pad);
    logic [HW-1:0] h;
    h = '0;
    for (int l = 0; l < 8; l++) if (lmask[l]) h[l*NPAD + pad] = 1'b1;
    return h;
  endfunction

  // Independent model: spread each pad over the towers it covers
  task automatic model(input logic [HW-1:0] h, input logic [11:0] bx, input logic [4:0] ph);
    bit cov [8][NTOW];
    for (int l = 0; l < 8; l++)
      for (int t = 0; t < NTOW; t++) cov[l][t] = 1'b0;
    for (int l = 0; l < 8; l++)
      for (int p = 0; p < NPAD; p++)
        if (h[l*NPAD + p]) begin
          int t0;
          t0 = 2*p + (l % 2);
          cov[l][t0] = 1'b1;
          if (t0 + 1 < NTOW) cov[l][t0+1] = 1'b1;
        end
    exp_n = 0;
    for (int t = 0; t < NTOW; t++) begin
      int a, b;
      a = int'(cov[0][t]) + int'(cov[1][t]) + int'(cov[2][t]) + int'(cov[3][t]);
      b = int'(cov[4][t]) + int'(cov[5][t]) + int'(cov[6][t]) + int'(cov[7][t]);
      if (a >= 3 && b >= 3 && exp_n < 3) begin
        exp_w[exp_n] = {bx, 8'(16 + 3*t), ph};
        exp_n++;
      end
    end
  endtask

  // Strobe one crossing, capture the framed output and compare (R7..R10)
  task automatic run_cross(input logic [HW-1:0] h, input logic [11:0] bx,
                           input logic [4:0] ph, input string req, input int want_n);
    bit fr [NCAP];
    bit l0 [NCAP];
    bit l1 [NCAP];
    int len, ones;
    model(h, bx, ph);
    chk(exp_n == want_n, req, "model road count", exp_n, want_n);
    @(negedge clk);
    pad_hits = h; bx_num = bx; sector_phi = ph; bx_stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bx_stb = 1'b0; pad_hits = '0;
    chk(frame_o == 1'b0, "R10", "frame after strobe edge", frame_o, 0);
    @(posedge clk);
    @(negedge clk);
    chk(frame_o == 1'b0, "R10", "frame one edge later", frame_o, 0);
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < NCAP; k++) begin
      fr[k] = frame_o; l0[k] = lane0_o; l1[k] = lane1_o;
      @(posedge clk);
      @(negedge clk);
    end
    chk(fr[0] == (exp_n > 0), "R10", "first frame cycle", fr[0], exp_n > 0);
    len = 0; ones = 0;
    for (int k = 0; k < NCAP; k++) begin
      if (fr[k]) ones++;
      if (fr[k] && len == k) len++;
    end
    chk(len == 13*exp_n && ones == len, (exp_n == 0) ? "R11" : "R9",
        "frame length", ones, 13*exp_n);
    for (int j = 0; j < exp_n; j++) begin
      logic [24:0] w;
      w = '0;
      for (int k = 0; k < 13; k++) begin
        w[24 - 2*k] = l0[j*13 + k];
        if (k < 12) w[23 - 2*k] = l1[j*13 + k];
        else chk(l1[j*13 + k] == 1'b0, "R8", "pad bit on lane1", l1[j*13+k], 0);
      end
      chk(w == exp_w[j], (j > 0) ? "R5" : "R7", "road word", w, exp_w[j]);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bx_stb = 1'b0; bx_num = '0; pad_hits = '0; sector_phi = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({frame_o, lane0_o, lane1_o} == 3'b000, "R1", "outputs in reset",
        {frame_o, lane0_o, lane1_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({frame_o, lane0_o, lane1_o} == 3'b000, "R1", "outputs after reset",
        {frame_o, lane0_o, lane1_o}, 0);
  endtask

  // R2 R3 R6: three inner layers plus four outer layers on pad 4 -> tower 9
  task automatic t_single;
    run_cross(mk(8'b1111_0111, 4), 12'hA5C, 5'd19, "R2", 1);
    chk(exp_w[0][12:5] == 8'd43, "R6", "band of tower 9", exp_w[0][12:5], 43);
  endtask

  // R2: two layers per quadruplet are not enough
  task automatic t_two_of_four;
    run_cross(mk(8'b0011_0011, 6), 12'h123, 5'd7, "R2", 0);
  endtask

  // R4: one-sided, then mismatched towers
  task automatic t_quad_disagree;
    run_cross(mk(8'b0000_1111, 8), 12'h0F0, 5'd3, "R4", 0);
    run_cross(mk(8'b0000_1111, 4) | mk(8'b1111_0000, 10), 12'h0F1, 5'd3, "R4", 0);
  endtask

  // R5: five roads, lowest three kept in ascending order
  task automatic t_overflow;
    logic [HW-1:0] h;
    h = mk(8'hFF, 1) | mk(8'hFF, 3) | mk(8'hFF, 5) | mk(8'hFF, 7) | mk(8'hFF, 9);
    run_cross(h, 12'hFFF, 5'd31, "R5", 3);
    chk(exp_w[2][12:5] == 8'(16 + 3*11), "R5", "third kept band", exp_w[2][12:5], 16+33);
  endtask

  // R5 R9: exactly three roads, scattered
  task automatic t_three;
    run_cross(mk(8'hFF, 12) | mk(8'hFF, 2) | mk(8'hFF, 6), 12'h800, 5'd0, "R9", 3);
  endtask

  // R3: last tower of the grid, and tower 0 reachable only by even layers
  task automatic t_edges;
    run_cross(mk(8'hFF, 15), 12'h3C3, 5'd21, "R3", 1);
    chk(exp_w[0][12:5] == 8'(16 + 3*31), "R3", "top tower band", exp_w[0][12:5], 16+93);
    run_cross(mk(8'hFF, 0), 12'h001, 5'd9, "R3", 1);
  endtask

  // R12: hits without a strobe stay silent
  task automatic t_idle_hits;
    int seen;
    seen = 0;
    @(negedge clk);
    pad_hits = mk(8'hFF, 5) | mk(8'hFF, 11);
    bx_stb = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (frame_o || lane0_o || lane1_o) seen++;
    end
    pad_hits = '0;
    chk(seen == 0, "R12", "activity without strobe", seen, 0);
  endtask

  // R11: strobed crossing with no hits
  task automatic t_empty;
    run_cross('0, 12'h555, 5'd10, "R11", 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=expired expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_two_of_four();
    t_quad_disagree();
    t_overflow();
    t_three();
    t_edges();
    t_idle_hits();
    t_empty();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule